// File: doc/BRIEF.md
# Digital I/O Port with Change-of-State Interrupt

This block is a byte-addressed digital I/O peripheral. It holds latches for 24 driven output lines and for one 8-bit logic-level bank. It samples 24 isolated input lines and the logic-level pins. A control bit chooses whether the logic-level bank drives its pins from its latch or acts as an input.

All 32 sampled input bits feed a change-of-state detector. Each 8-bit bank has its own rising-edge enable and its own falling-edge enable. A detected edge sets a sticky status bit, and software clears that bit by writing a one to it. One level-sensitive interrupt line is high while any status bit is set.

Software reaches the block in two ways:
- A synchronous bus with a 4-bit address and 8-bit data. Reads return data combinationally from the addressed register.
- A separate 32-bit port that reads and clears the whole status window at once.

A write to the top address resets the register state of the block.

Top module: `dio_cos_ctrl`

## Requirements
- R1: Byte addresses 0, 1 and 2 hold output lines 7:0, 15:8 and 23:16. A write updates `out_lines` on the next clock edge, and a read returns the last value written.
- R2: Address 3 holds the logic-level output latch. `lvl_out` always shows this latch, and a read of address 3 returns it.
- R3: Address 12 is the control register. Only bit 1 is stored; it is the output-mode bit and drives `lvl_oe`. The other bits read as 0.
- R4: Addresses 4, 5 and 6 read isolated inputs 7:0, 15:8 and 23:16. Address 7 reads the logic-level pins. Each input passes through a two-stage synchronizer before it is readable.
- R5: Writes to addresses 4 to 7 and to the reserved address 13 change no register state. Address 13 reads 0.
- R6: Status bits are numbered 0 to 31. Bank k covers status bits 8k to 8k+7, so bank 0 is isolated inputs 7:0 and bank 3 is the logic-level pins. In the enable register at address 14, bit k enables rising-edge detection for bank k and bit k+4 enables falling-edge detection. A status bit is set no later than three clock edges after its pin makes an enabled transition.
- R7: A transition in a bank whose enable for that edge direction is 0 sets no status bit.
- R8: Status bits are sticky. Addresses 8 to 11 read status banks 0 to 3. A byte write to one of these addresses clears exactly the bits written as 1.
- R9: `word_rdata` always shows all 32 status bits, with bank k in bits 8k+7:8k. A write on the word port clears every status bit written as 1.
- R10: If a new edge and a clear of the same status bit land on the same clock edge, the bit stays set.
- R11: `irq` is high exactly when any status bit is set. A read of address 15 returns `irq` in bit 0, with the other bits 0.
- R12: Any write to address 15 clears, on the next clock edge, the output latches, the control register, the edge enables and all status bits.
- R13: After hardware reset all latches, the control register, the enables and the status are 0, and the logic-level bank is an input (`lvl_oe` low).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte register address |
| bus_wen | input | 1 | Byte write strobe |
| bus_wdata | input | 8 | Byte write data |
| bus_rdata | output | 8 | Byte read data for `bus_addr` |
| word_wen | input | 1 | Status window word write (clear) strobe |
| word_wdata | input | 32 | Word of status bits to clear |
| word_rdata | output | 32 | All four status bytes |
| out_lines | output | 24 | Driven output lines |
| iso_in | input | 24 | Isolated input lines |
| lvl_in | input | 8 | Logic-level pin values |
| lvl_out | output | 8 | Logic-level drive values |
| lvl_oe | output | 1 | Logic-level bank output enable |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check on every cycle that the interrupt equals the OR of the status word. They also check that status bits never drop unless a clear or reset write occurred, and that no bit rises while all edge enables are zero. On the cycle after the relevant write, they check the result of a control write, of a first output byte write, and of a soft reset.

The exact mapping of each enable bit to its bank and edge direction can only be shown by the bench's scenarios, which compare against a reference model. The same holds for the synchronizer latency seen at the read addresses, for the outcome when an edge and a clear collide on one clock edge, and for the lack of effect of writes to the read-only and reserved addresses.

// File: rtl/dio_cos_pkg.sv
package dio_cos_pkg;
    localparam int BYTE_W      = 8;
    localparam int N_FET_BYTES = 3;
    localparam int N_ISO_BYTES = 3;
    localparam int N_BANKS     = N_ISO_BYTES + 1;
    localparam int FET_W       = N_FET_BYTES * BYTE_W;
    localparam int ISO_W       = N_ISO_BYTES * BYTE_W;
    localparam int COS_W       = N_BANKS * BYTE_W;
    localparam int EN_W        = 2 * N_BANKS;

    localparam logic [3:0] A_FET0    = 4'd0;
    localparam logic [3:0] A_LVL_OUT = 4'd3;
    localparam logic [3:0] A_ISO0    = 4'd4;
    localparam logic [3:0] A_LVL_IN  = 4'd7;
    localparam logic [3:0] A_COS0    = 4'd8;
    localparam logic [3:0] A_CTL     = 4'd12;
    localparam logic [3:0] A_RSVD    = 4'd13;
    localparam logic [3:0] A_COS_EN  = 4'd14;
    localparam logic [3:0] A_RESET   = 4'd15;

    localparam int CTL_MODE_BIT = 1;

    typedef struct packed {
        logic [N_FET_BYTES-1:0][BYTE_W-1:0] fet;
        logic [BYTE_W-1:0]                  lvl;
        logic                               mode;
        logic [EN_W-1:0]                    en;
    } regs_t;
endpackage

// File: rtl/dio_sync.sv
module dio_sync #(
    parameter int W      = 8,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [STAGES-1:0][W-1:0] stg_d, stg_q;

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q <= '0;
        else        stg_q <= stg_d;
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/dio_cos_detect.sv
module dio_cos_detect #(
    parameter int BANKS = 4,
    parameter int BW    = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [BANKS*BW-1:0] smp,
    input  logic [BANKS-1:0]   rise_en,
    input  logic [BANKS-1:0]   fall_en,
    input  logic [BANKS*BW-1:0] clr,
    input  logic               flush,
    output logic [BANKS*BW-1:0] status,
    output logic               any_set
);
    localparam int W = BANKS * BW;

    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] st;
    } cos_t;

    cos_t         cos_d, cos_q;
    logic [W-1:0] hit;

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        assign hit[b*BW +: BW] =
              ({BW{rise_en[b]}} &  smp[b*BW +: BW] & ~cos_q.prev[b*BW +: BW])
            | ({BW{fall_en[b]}} & ~smp[b*BW +: BW] &  cos_q.prev[b*BW +: BW]);
    end

    always_comb begin
        cos_d.prev = smp;
        if (flush) cos_d.st = '0;
        else       cos_d.st = (cos_q.st & ~clr) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cos_q <= '0;
        else        cos_q <= cos_d;
    end

    assign status  = cos_q.st;
    assign any_set = |cos_q.st;
endmodule

// File: rtl/dio_rd_mux.sv
module dio_rd_mux
    import dio_cos_pkg::*;
(
    input  logic [3:0]        addr,
    input  regs_t             regs,
    input  logic [ISO_W-1:0]  iso_s,
    input  logic [BYTE_W-1:0] lvl_s,
    input  logic [COS_W-1:0]  status,
    input  logic              irq,
    output logic [BYTE_W-1:0] rdata
);
    always_comb begin
        rdata = '0;
        case (addr)
            4'd0:     rdata = regs.fet[0];
            4'd1:     rdata = regs.fet[1];
            4'd2:     rdata = regs.fet[2];
            A_LVL_OUT: rdata = regs.lvl;
            4'd4:     rdata = iso_s[7:0];
            4'd5:     rdata = iso_s[15:8];
            4'd6:     rdata = iso_s[23:16];
            A_LVL_IN: rdata = lvl_s;
            4'd8:     rdata = status[7:0];
            4'd9:     rdata = status[15:8];
            4'd10:    rdata = status[23:16];
            4'd11:    rdata = status[31:24];
            A_CTL:    rdata[CTL_MODE_BIT] = regs.mode;
            A_COS_EN: rdata = regs.en;
            A_RESET:  rdata[0] = irq;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/dio_cos_ctrl.sv
module dio_cos_ctrl
    import dio_cos_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        bus_addr,
    input  logic              bus_wen,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              word_wen,
    input  logic [31:0]       word_wdata,
    output logic [31:0]       word_rdata,
    output logic [23:0]       out_lines,
    input  logic [23:0]       iso_in,
    input  logic [7:0]        lvl_in,
    output logic [7:0]        lvl_out,
    output logic              lvl_oe,
    output logic              irq
);
    regs_t             regs_d, regs_q;
    logic [COS_W-1:0]  clr_mask;
    logic              soft_rst;
    logic [COS_W-1:0]  smp;
    logic [COS_W-1:0]  status;
    logic              any_set;
    logic [EN_W-1:0]   cos_en_now;

    always_comb begin
        regs_d   = regs_q;
        clr_mask = '0;
        soft_rst = 1'b0;
        if (bus_wen) begin
            for (int b = 0; b < N_FET_BYTES; b++) begin
                if (bus_addr == A_FET0 + 4'(b)) regs_d.fet[b] = bus_wdata;
            end
            for (int k = 0; k < N_BANKS; k++) begin
                if (bus_addr == A_COS0 + 4'(k)) clr_mask[k*BYTE_W +: BYTE_W] = bus_wdata;
            end
            if (bus_addr == A_LVL_OUT) regs_d.lvl  = bus_wdata;
            if (bus_addr == A_CTL)     regs_d.mode = bus_wdata[CTL_MODE_BIT];
            if (bus_addr == A_COS_EN)  regs_d.en   = bus_wdata;
            if (bus_addr == A_RESET) begin
                soft_rst = 1'b1;
                regs_d   = '0;
            end
        end
        if (word_wen) clr_mask = clr_mask | word_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    dio_sync #(.W(COS_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({lvl_in, iso_in}),
        .q     (smp)
    );

    dio_cos_detect #(.BANKS(N_BANKS), .BW(BYTE_W)) u_cos (
        .clk     (clk),
        .rst_n   (rst_n),
        .smp     (smp),
        .rise_en (regs_q.en[N_BANKS-1:0]),
        .fall_en (regs_q.en[EN_W-1:N_BANKS]),
        .clr     (clr_mask),
        .flush   (soft_rst),
        .status  (status),
        .any_set (any_set)
    );

    dio_rd_mux u_rd (
        .addr   (bus_addr),
        .regs   (regs_q),
        .iso_s  (smp[ISO_W-1:0]),
        .lvl_s  (smp[COS_W-1:ISO_W]),
        .status (status),
        .irq    (any_set),
        .rdata  (bus_rdata)
    );

    assign cos_en_now = regs_q.en;
    assign word_rdata = status;
    assign out_lines  = regs_q.fet;
    assign lvl_out    = regs_q.lvl;
    assign lvl_oe     = regs_q.mode;
    assign irq        = any_set;
endmodule

// File: rtl/dio_cos_ctrl_chk.sv
module dio_cos_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [3:0]  bus_addr,
    input logic        bus_wen,
    input logic [7:0]  bus_wdata,
    input logic        word_wen,
    input logic [31:0] word_rdata,
    input logic [23:0] out_lines,
    input logic        lvl_oe,
    input logic        irq,
    input logic [7:0]  cos_en
);
    a_r11_irq_is_or: assert property (@(posedge clk) disable iff (!rst_n)
        irq == (word_rdata != 32'h0));

    a_r12_soft_reset_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == 4'd15) |=>
        (out_lines == 24'h0 && word_rdata == 32'h0 && !lvl_oe && cos_en == 8'h0));

    a_r3_mode_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == 4'd12) |=> (lvl_oe == $past(bus_wdata[1])));

    a_r1_low_byte_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wen && bus_addr == 4'd0) |=> (out_lines[7:0] == $past(bus_wdata)));

    a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wen && !word_wen) |=> ((word_rdata & $past(word_rdata)) == $past(word_rdata)));

    a_r7_no_set_when_disabled: assert property (@(posedge clk) disable iff (!rst_n)
        (cos_en == 8'h0) |=> ((word_rdata & ~$past(word_rdata)) == 32'h0));
endmodule

bind dio_cos_ctrl dio_cos_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_addr   (bus_addr),
    .bus_wen    (bus_wen),
    .bus_wdata  (bus_wdata),
    .word_wen   (word_wen),
    .word_rdata (word_rdata),
    .out_lines  (out_lines),
    .lvl_oe     (lvl_oe),
    .irq        (irq),
    .cos_en     (cos_en_now)
);

// File: tb/dio_cos_ctrl_test.sv
`timescale 1ns/1ps
module dio_cos_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_wen = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        word_wen = 1'b0;
    logic [31:0] word_wdata = '0;
    logic [31:0] word_rdata;
    logic [23:0] out_lines;
    logic [23:0] iso_in = '0;
    logic [7:0]  lvl_in = '0;
    logic [7:0]  lvl_out;
    logic        lvl_oe;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [23:0] m_fet;
    logic [7:0]  m_lvl;
    logic        m_mode;
    logic [7:0]  m_en;
    logic [31:0] m_st;

    always #2 clk = ~clk;

    dio_cos_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wen(bus_wen),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .word_wen(word_wen),
        .word_wdata(word_wdata), .word_rdata(word_rdata), .out_lines(out_lines),
        .iso_in(iso_in), .lvl_in(lvl_in), .lvl_out(lvl_out), .lvl_oe(lvl_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
        @(negedge clk);
        bus_wen = 1'b0;
    endtask

    task automatic wclr(input logic [31:0] m);
        @(negedge clk);
        word_wdata = m; word_wen = 1'b1;
        @(negedge clk);
        word_wen = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] edges(input logic [31:0] o, input logic [31:0] n,
                                          input logic [7:0] en);
        logic [31:0] r = '0;
        for (int k = 0; k < 4; k++) begin
            if (en[k])   r[k*8 +: 8] = r[k*8 +: 8] | ( n[k*8 +: 8] & ~o[k*8 +: 8]);
            if (en[k+4]) r[k*8 +: 8] = r[k*8 +: 8] | (~n[k*8 +: 8] &  o[k*8 +: 8]);
        end
        return r;
    endfunction

    task automatic set_in(input logic [23:0] ni, input logic [7:0] nl);
        logic [31:0] old;
        @(negedge clk);
        old = {lvl_in, iso_in};
        iso_in = ni; lvl_in = nl;
        repeat (4) @(negedge clk);
        m_st = m_st | edges(old, {nl, ni}, m_en);
    endtask

    task automatic model_zero();
        m_fet = '0; m_lvl = '0; m_mode = 1'b0; m_en = '0; m_st = '0;
    endtask

    task automatic chk_regs();
        logic [7:0] v;
        rd(4'd0, v);  chk("R1 addr0", v, m_fet[7:0]);
        rd(4'd1, v);  chk("R1 addr1", v, m_fet[15:8]);
        rd(4'd2, v);  chk("R1 addr2", v, m_fet[23:16]);
        chk("R1 out_lines", out_lines, m_fet);
        rd(4'd3, v);  chk("R2 addr3", v, m_lvl);
        chk("R2 lvl_out", lvl_out, m_lvl);
        rd(4'd12, v); chk("R3 ctl", v, {6'b0, m_mode, 1'b0});
        chk("R3 lvl_oe", lvl_oe, m_mode);
        rd(4'd4, v);  chk("R4 iso lo", v, iso_in[7:0]);
        rd(4'd5, v);  chk("R4 iso mid", v, iso_in[15:8]);
        rd(4'd6, v);  chk("R4 iso hi", v, iso_in[23:16]);
        rd(4'd7, v);  chk("R4 lvl in", v, lvl_in);
        rd(4'd13, v); chk("R5 reserved", v, 8'h00);
        rd(4'd14, v); chk("R6 enable", v, m_en);
        for (int k = 0; k < 4; k++) begin
            rd(4'(8 + k), v); chk("R8 status byte", v, m_st[k*8 +: 8]);
        end
        chk("R9 word", word_rdata, m_st);
        chk("R11 irq", irq, |m_st);
        rd(4'd15, v); chk("R11 addr15", v, {7'b0, |m_st});
    endtask

    initial begin
        #(4.0 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        model_zero();
        r = $urandom(32'd20250611);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R13: reset state
        chk("R13 lvl_oe", lvl_oe, 1'b0);
        chk_regs();

        // R1 R2 R3 directed
        wr(4'd0, 8'h5A); m_fet[7:0]   = 8'h5A;
        wr(4'd1, 8'hC3); m_fet[15:8]  = 8'hC3;
        wr(4'd2, 8'h81); m_fet[23:16] = 8'h81;
        wr(4'd3, 8'h3C); m_lvl = 8'h3C;
        wr(4'd12, 8'hFF); m_mode = 1'b1;
        chk_regs();
        wr(4'd12, 8'hFD); m_mode = 1'b0;
        chk_regs();

        // R4 R7: inputs with all enables off
        set_in(24'hA1B2C3, 8'h7E);
        chk_regs();

        // R5: writes to read-only and reserved addresses
        wr(4'd4, 8'hFF); wr(4'd5, 8'hFF); wr(4'd6, 8'hFF); wr(4'd7, 8'hFF); wr(4'd13, 8'hFF);
        chk_regs();

        // R6: rising only on bank 0, falling only on bank 3
        wr(4'd14, 8'h81); m_en = 8'h81;
        set_in(24'hA1B2CF, 8'h7E);   // bank0 rising bits 2,3
        chk("R6 rise bank0", word_rdata, 32'h0000_000C);
        set_in(24'hA1B2C0, 8'h3F);   // bank0 falling ignored; bank3 bit6 falls, bit0 rises (ignored)
        chk("R6 fall bank3", word_rdata, 32'h4000_000C);
        chk_regs();

        // R8 byte clear, R9 word clear
        wr(4'd8, 8'h04); m_st[2] = 1'b0;
        chk("R8 byte clear", word_rdata, 32'h4000_0008);
        wclr(32'h4000_0000); m_st[30] = 1'b0;
        chk("R9 word clear", word_rdata, 32'h0000_0008);
        wclr(32'hFFFF_FFFF); m_st = '0;
        chk("R11 irq low", irq, 1'b0);

        // R10: edge and clear on the same clock edge
        wr(4'd14, 8'hFF); m_en = 8'hFF;
        set_in(iso_in ^ 24'h000100, lvl_in);
        chk("R10 setup", word_rdata, 32'h0000_0100);
        @(negedge clk); iso_in[8] = ~iso_in[8];
        @(negedge clk);
        @(negedge clk); bus_addr = 4'd9; bus_wdata = 8'h01; bus_wen = 1'b1;
        @(negedge clk); bus_wen = 1'b0;
        chk("R10 edge wins", word_rdata, 32'h0000_0100);
        wr(4'd9, 8'h01); m_st = '0;
        chk("R8 clear after race", word_rdata, 32'h0);

        // R12: soft reset
        set_in(iso_in ^ 24'h800000, lvl_in ^ 8'h01);
        wr(4'd0, 8'hEE); m_fet[7:0] = 8'hEE;
        wr(4'd12, 8'h02); m_mode = 1'b1;
        chk_regs();
        wr(4'd15, 8'h00); model_zero();
        chk("R12 oe low", lvl_oe, 1'b0);
        chk_regs();

        // Random mix
        for (int it = 0; it < 150; it++) begin
            r = $urandom;
            case (r[2:0])
                3'd0: begin wr(4'(r[9:8]), r[23:16]);
                        if (r[9:8] == 2'd3) m_lvl = r[23:16];
                        else m_fet[r[9:8]*8 +: 8] = r[23:16]; end
                3'd1: begin wr(4'd12, r[23:16]); m_mode = r[17]; end
                3'd2: begin wr(4'd14, r[23:16]); m_en = r[23:16]; end
                3'd3, 3'd4: set_in($urandom, r[31:24]);
                3'd5: begin wr(4'(8 + r[9:8]), r[23:16]);
                        m_st[r[9:8]*8 +: 8] = m_st[r[9:8]*8 +: 8] & ~r[23:16]; end
                3'd6: begin logic [31:0] m = $urandom; wclr(m); m_st = m_st & ~m; end
                default: begin
                    if (r[12]) begin wr(4'd15, r[23:16]); model_zero(); end
                    else wr(4'(4 + r[9:8]), r[23:16]);
                end
            endcase
            chk_regs();
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule